// File: doc/BRIEF.md
# Receive Frame Length Screening and Counters

This block sits at the end of a receive path and looks at each frame once it has fully arrived. For every frame it is given two byte counts: the count without the four-byte frame check sequence, and the count with it. It also gets two control bits. One allows jumbo-sized frames. The other tells the receiver to keep bad frames. From these it decides whether the frame is too long and must be discarded, and it keeps a set of receive statistics.

All counters saturate: once a counter reaches its largest value, it stays there and does not wrap. The set is an oversize counter, six size-bucket counters, a total-frame counter, a good-frame counter that always mirrors the total, and two wide byte counters. The first byte counter is the total. The second is a good-byte counter that mirrors it. The drop decision and every counter update appear together, one clock after the end-of-frame strobe.

Top module: `rx_len_stats`

## Requirements
- R1: With `jumbo_en` low, a frame whose `len_nofcs` exceeds 1522 is oversized.
- R2: A frame whose `len_nofcs` exceeds 16384 is oversized whatever `jumbo_en` is; with `jumbo_en` high, lengths up to 16384 are accepted.
- R3: While `keep_bad` is high, no frame is oversized: `drop` stays low and the frame is counted as accepted.
- R4: For an oversized frame, `drop` is high for exactly the one cycle after the strobe, and `oversize_cnt` rises by one in that same cycle.
- R5: An accepted frame adds one to exactly one bucket of `size_bins`, chosen from `len_fcs`: index 0 for exactly 64, 1 for 65..127, 2 for 128..255, 3 for 256..511, 4 for 512..1023, and 5 for above 1023. A frame with `len_fcs` below 64 touches no bucket.
- R6: Every accepted frame adds one to `rx_frames`, and `good_frames` always equals `rx_frames`.
- R7: An accepted frame adds `len_nofcs` + 4 to `rx_bytes`, and `good_bytes` always equals `rx_bytes`.
- R8: Every counter stops at all ones and never wraps. This includes the byte counter when a single addition would pass its maximum.
- R9: An oversized frame leaves the buckets, the frame counters and the byte counters unchanged.
- R10: Reset clears every counter and `drop`. Without a strobe, no counter changes and `drop` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe marking the end of a received frame |
| len_nofcs | input | LEN_W | Frame length in bytes without the check sequence |
| len_fcs | input | LEN_W | Frame length in bytes including the check sequence |
| jumbo_en | input | 1 | Raises the length limit from 1522 to 16384 |
| keep_bad | input | 1 | Disables the oversize discard |
| drop | output | 1 | Frame judged oversized, valid the cycle after the strobe |
| oversize_cnt | output | CNT_W | Saturating count of oversized frames |
| size_bins | output | 6 x CNT_W | Saturating size-bucket counters, index as in R5 |
| rx_frames | output | CNT_W | Saturating count of accepted frames |
| good_frames | output | CNT_W | Mirror of rx_frames |
| rx_bytes | output | OCT_W | Saturating byte total of accepted frames |
| good_bytes | output | OCT_W | Mirror of rx_bytes |

## Verification
Each result has exactly one register between the strobe and the port. So `drop` and every counter must show the new frame at the first clock edge after the strobe, and at no other edge. The bench raises the strobe just after a falling edge and lowers it at the next falling edge. At that point it compares every output against its own model, so each check lands half a period after the single edge that carries the update. The idle test lets several cycles pass with no strobe and checks that nothing moved and that `drop` had already returned low. To reach saturation within a short run, the bench instantiates the block with narrow counters.

// File: rtl/rx_len_stats_pkg.sv
package rx_len_stats_pkg;

    localparam int unsigned STD_MAX_LEN   = 1522;
    localparam int unsigned JUMBO_MAX_LEN = 16384;
    localparam int unsigned FCS_BYTES     = 4;
    localparam int unsigned NUM_BINS      = 6;
    localparam int unsigned BIN_IDX_W     = $clog2(NUM_BINS);

    typedef struct packed {
        logic                 hit;
        logic [BIN_IDX_W-1:0] idx;
    } bin_sel_t;

    typedef struct packed {
        logic oversize;
        logic accept;
    } verdict_t;

    function automatic bin_sel_t pick_bin(input int unsigned len);
        bin_sel_t s;
        s.hit = 1'b1;
        if (len > 1023)      s.idx = BIN_IDX_W'(5);
        else if (len > 511)  s.idx = BIN_IDX_W'(4);
        else if (len > 255)  s.idx = BIN_IDX_W'(3);
        else if (len > 127)  s.idx = BIN_IDX_W'(2);
        else if (len > 64)   s.idx = BIN_IDX_W'(1);
        else if (len == 64)  s.idx = BIN_IDX_W'(0);
        else begin
            s.hit = 1'b0;
            s.idx = '0;
        end
        return s;
    endfunction

    function automatic logic too_long(input int unsigned len, input logic jumbo,
                                      input logic keep);
        logic over;
        over = (len > JUMBO_MAX_LEN) || ((len > STD_MAX_LEN) && !jumbo);
        return over && !keep;
    endfunction

endpackage

// File: rtl/rxlen_limit_check.sv
module rxlen_limit_check
    import rx_len_stats_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             strobe,
    input  logic [LEN_W-1:0] len_nofcs,
    input  logic             jumbo_en,
    input  logic             keep_bad,
    output verdict_t         verdict
);

    logic over;

    always_comb begin
        over             = too_long(32'(len_nofcs), jumbo_en, keep_bad);
        verdict.oversize = strobe && over;
        verdict.accept   = strobe && !over;
    end

endmodule

// File: rtl/rxlen_bin_pick.sv
module rxlen_bin_pick
    import rx_len_stats_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             accept,
    input  logic [LEN_W-1:0] len_fcs,
    output logic [NUM_BINS-1:0] bin_en
);

    bin_sel_t sel;

    assign sel = pick_bin(32'(len_fcs));

    for (genvar i = 0; i < NUM_BINS; i++) begin : g_dec
        assign bin_en[i] = accept && sel.hit && (sel.idx == BIN_IDX_W'(i));
    end

endmodule

// File: rtl/rxstat_sat_acc.sv
module rxstat_sat_acc #(
    parameter int W     = 32,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [W-1:0]     value
);

    localparam int SW = ((W > INC_W) ? W : INC_W) + 1;

    logic [SW-1:0] sum;
    logic [W-1:0]  nxt;

    assign sum = SW'(value) + SW'(inc);

    always_comb begin
        nxt = value;
        if (en) begin
            if (|sum[SW-1:W]) nxt = '1;
            else              nxt = sum[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= nxt;
    end

endmodule

// File: rtl/rx_len_stats.sv
module rx_len_stats
    import rx_len_stats_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 32,
    parameter int OCT_W = 64
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             frame_done,
    input  logic [LEN_W-1:0]                 len_nofcs,
    input  logic [LEN_W-1:0]                 len_fcs,
    input  logic                             jumbo_en,
    input  logic                             keep_bad,
    output logic                             drop,
    output logic [CNT_W-1:0]                 oversize_cnt,
    output logic [NUM_BINS-1:0][CNT_W-1:0]   size_bins,
    output logic [CNT_W-1:0]                 rx_frames,
    output logic [CNT_W-1:0]                 good_frames,
    output logic [OCT_W-1:0]                 rx_bytes,
    output logic [OCT_W-1:0]                 good_bytes
);

    localparam int ADD_W = LEN_W + 1;

    verdict_t            verdict;
    logic [NUM_BINS-1:0] bin_en;
    logic [ADD_W-1:0]    byte_add;

    rxlen_limit_check #(.LEN_W(LEN_W)) u_limit (
        .strobe    (frame_done),
        .len_nofcs (len_nofcs),
        .jumbo_en  (jumbo_en),
        .keep_bad  (keep_bad),
        .verdict   (verdict)
    );

    rxlen_bin_pick #(.LEN_W(LEN_W)) u_bins (
        .accept  (verdict.accept),
        .len_fcs (len_fcs),
        .bin_en  (bin_en)
    );

    assign byte_add = ADD_W'(len_nofcs) + ADD_W'(FCS_BYTES);

    always_ff @(posedge clk) begin
        if (rst) drop <= 1'b0;
        else     drop <= verdict.oversize;
    end

    rxstat_sat_acc #(.W(CNT_W), .INC_W(1)) u_ovs (
        .clk (clk), .rst (rst), .en (verdict.oversize), .inc (1'b1),
        .value (oversize_cnt)
    );

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        rxstat_sat_acc #(.W(CNT_W), .INC_W(1)) u_cnt (
            .clk (clk), .rst (rst), .en (bin_en[b]), .inc (1'b1),
            .value (size_bins[b])
        );
    end

    rxstat_sat_acc #(.W(CNT_W), .INC_W(1)) u_tot_frames (
        .clk (clk), .rst (rst), .en (verdict.accept), .inc (1'b1),
        .value (rx_frames)
    );

    rxstat_sat_acc #(.W(CNT_W), .INC_W(1)) u_good_frames (
        .clk (clk), .rst (rst), .en (verdict.accept), .inc (1'b1),
        .value (good_frames)
    );

    rxstat_sat_acc #(.W(OCT_W), .INC_W(ADD_W)) u_tot_bytes (
        .clk (clk), .rst (rst), .en (verdict.accept), .inc (byte_add),
        .value (rx_bytes)
    );

    rxstat_sat_acc #(.W(OCT_W), .INC_W(ADD_W)) u_good_bytes (
        .clk (clk), .rst (rst), .en (verdict.accept), .inc (byte_add),
        .value (good_bytes)
    );

endmodule

// File: rtl/rx_len_stats_chk.sv
module rx_len_stats_chk #(
    parameter int CNT_W = 32,
    parameter int OCT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_done,
    input logic             keep_bad,
    input logic             drop,
    input logic [CNT_W-1:0] oversize_cnt,
    input logic [CNT_W-1:0] rx_frames,
    input logic [CNT_W-1:0] good_frames,
    input logic [OCT_W-1:0] rx_bytes,
    input logic [OCT_W-1:0] good_bytes
);

    AST_KEEP_BAD_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        $past(frame_done && keep_bad) |-> !drop); // R3

    AST_DROP_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        drop |-> $past(frame_done)); // R4

    AST_DROP_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (drop && $past(oversize_cnt) != '1) |-> oversize_cnt != $past(oversize_cnt)); // R4

    AST_GOOD_FRAMES_MIRROR: assert property (@(posedge clk) disable iff (rst)
        good_frames == rx_frames); // R6

    AST_GOOD_BYTES_MIRROR: assert property (@(posedge clk) disable iff (rst)
        good_bytes == rx_bytes); // R7

    AST_FRAMES_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        rx_frames >= $past(rx_frames)); // R8

    AST_BYTES_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        rx_bytes >= $past(rx_bytes)); // R8

    AST_OVS_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        oversize_cnt >= $past(oversize_cnt)); // R8

    AST_DROP_FREEZES_TOTALS: assert property (@(posedge clk) disable iff (rst)
        drop |-> ($stable(rx_frames) && $stable(rx_bytes))); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_done) |-> ($stable(rx_frames) && $stable(rx_bytes) &&
                                $stable(oversize_cnt) && !drop)); // R10

endmodule

bind rx_len_stats rx_len_stats_chk #(.CNT_W(CNT_W), .OCT_W(OCT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_done   (frame_done),
    .keep_bad     (keep_bad),
    .drop         (drop),
    .oversize_cnt (oversize_cnt),
    .rx_frames    (rx_frames),
    .good_frames  (good_frames),
    .rx_bytes     (rx_bytes),
    .good_bytes   (good_bytes)
);

// File: tb/rx_len_stats_test.sv
`timescale 1ns/1ps
module rx_len_stats_test;

    localparam int LEN_W = 16;
    localparam int CNT_W = 4;
    localparam int OCT_W = 16;
    localparam int NB    = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_done = 1'b0;
    logic [LEN_W-1:0] len_nofcs = '0;
    logic [LEN_W-1:0] len_fcs = '0;
    logic jumbo_en = 1'b0;
    logic keep_bad = 1'b0;
    logic drop;
    logic [CNT_W-1:0] oversize_cnt;
    logic [NB-1:0][CNT_W-1:0] size_bins;
    logic [CNT_W-1:0] rx_frames, good_frames;
    logic [OCT_W-1:0] rx_bytes, good_bytes;

    int checks = 0;
    int fails  = 0;

    longint exp_ovs, exp_frames, exp_bytes;
    longint exp_bin [NB];

    always #2 clk = ~clk;

    rx_len_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W)) uut (
        .clk (clk), .rst (rst), .frame_done (frame_done),
        .len_nofcs (len_nofcs), .len_fcs (len_fcs),
        .jumbo_en (jumbo_en), .keep_bad (keep_bad), .drop (drop),
        .oversize_cnt (oversize_cnt), .size_bins (size_bins),
        .rx_frames (rx_frames), .good_frames (good_frames),
        .rx_bytes (rx_bytes), .good_bytes (good_bytes)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic longint sat_add(input longint v, input longint a, input int w);
        longint mx = (longint'(1) << w) - 1;
        return (v + a > mx) ? mx : v + a;
    endfunction

    task automatic check_all(input string req, input logic exp_drop);
        check(req, "drop", longint'(drop), longint'(exp_drop));
        check(req, "oversize", longint'(oversize_cnt), exp_ovs);
        check(req, "frames", longint'(rx_frames), exp_frames);
        check(req, "good_frames", longint'(good_frames), exp_frames);
        check(req, "bytes", longint'(rx_bytes), exp_bytes);
        check(req, "good_bytes", longint'(good_bytes), exp_bytes);
        for (int i = 0; i < NB; i++)
            check(req, $sformatf("bin%0d", i), longint'(size_bins[i]), exp_bin[i]);
    endtask

    // drives one frame and checks all outputs half a cycle after the update edge
    task automatic send(input string req, input int dl, input int fl,
                        input logic lpe, input logic sbp);
        logic ov;
        int b;
        ov = !sbp && (dl > 16384 || (dl > 1522 && !lpe));
        len_nofcs = LEN_W'(dl);
        len_fcs = LEN_W'(fl);
        jumbo_en = lpe;
        keep_bad = sbp;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        if (ov) exp_ovs = sat_add(exp_ovs, 1, CNT_W);
        else begin
            exp_frames = sat_add(exp_frames, 1, CNT_W);
            exp_bytes = sat_add(exp_bytes, dl + 4, OCT_W);
            b = (fl > 1023) ? 5 : (fl > 511) ? 4 : (fl > 255) ? 3 :
                (fl > 127) ? 2 : (fl > 64) ? 1 : (fl == 64) ? 0 : -1;
            if (b >= 0) exp_bin[b] = sat_add(exp_bin[b], 1, CNT_W);
        end
        check_all(req, ov);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_ovs = 0; exp_frames = 0; exp_bytes = 0;
        for (int i = 0; i < NB; i++) exp_bin[i] = 0;
        check_all("R10", 1'b0);
    endtask

    task automatic t_std_limit();
        send("R1", 1522, 1526, 1'b0, 1'b0);
        send("R1", 1523, 1527, 1'b0, 1'b0);
    endtask

    task automatic t_jumbo_limit();
        send("R2", 1523, 1527, 1'b1, 1'b0);
        send("R2", 16384, 16388, 1'b1, 1'b0);
        send("R2", 16385, 16389, 1'b1, 1'b0);
    endtask

    task automatic t_keep_bad();
        send("R3", 20000, 20004, 1'b0, 1'b1);
    endtask

    task automatic t_bins();
        do_reset();
        send("R5", 60, 64, 1'b0, 1'b0);
        send("R5", 61, 65, 1'b0, 1'b0);
        send("R5", 123, 127, 1'b0, 1'b0);
        send("R5", 124, 128, 1'b0, 1'b0);
        send("R5", 256, 260, 1'b0, 1'b0);
        send("R5", 600, 604, 1'b0, 1'b0);
        send("R5", 1020, 1024, 1'b0, 1'b0);
        send("R5", 50, 54, 1'b0, 1'b0);
        send("R5", 59, 63, 1'b0, 1'b0);
    endtask

    task automatic t_oversize_untouched();
        do_reset();
        send("R7", 100, 104, 1'b0, 1'b0);
        send("R9", 3000, 3004, 1'b0, 1'b0);
        send("R6", 200, 204, 1'b0, 1'b0);
    endtask

    task automatic t_idle();
        repeat (5) @(negedge clk);
        check_all("R10", 1'b0);
    endtask

    task automatic t_saturation();
        do_reset();
        for (int i = 0; i < 18; i++) send("R4", 2000, 2004, 1'b0, 1'b0);
        check("R8", "ovs_sat", longint'(oversize_cnt), 15);
        for (int i = 0; i < 9; i++) send("R8", 9000, 9004, 1'b1, 1'b0);
        check("R8", "bytes_sat", longint'(rx_bytes), 65535);
        for (int i = 0; i < 8; i++) send("R8", 60, 64, 1'b0, 1'b0);
        check("R8", "frames_sat", longint'(rx_frames), 15);
        check("R8", "bin0_sat", longint'(size_bins[0]), 8);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_std_limit();
        t_jumbo_limit();
        t_keep_bad();
        t_idle();
        t_bins();
        t_oversize_untouched();
        t_idle();
        t_saturation();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule